// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block sits between the status logic of a serial port and the processor's interrupt input. It watches five request conditions (receive line error, receive data at or above the threshold, receive character timeout, transmit holding register empty, and modem input change), gates them with a 4-bit enable mask, and drives one interrupt line. It also presents a 4-bit identification word that names the single highest-priority source that is both pending and enabled.

Software services an interrupt by reading the identification word and then doing whatever clears that source. Each source clears differently. The line error and modem change conditions are latched here and drop on their own status reads. The two receive conditions are levels that follow the receive data count, so they drop when enough data has been read. The transmit-empty request is a one-shot: it is latched on the empty event, and the act of reading the identification word while that request is the one reported clears it.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable mask `ien_q` is 0000. A write with `ien_wr` loads `ien_wdata` at the clock edge. During the write cycle `ien_q` still shows the value held before the write.
- R2: The fixed priority, highest first, is: line error (code 3), data at threshold (code 2), character timeout (code 6), transmit empty (code 1), modem change (code 0).
- R3: When no enabled source is pending, `iid` is 4'b0001 and `irq` is 0. Otherwise `iid` is {code[2:0],1'b0} and `irq` is 1.
- R4: Each mask bit gates its sources: bit0 gates both data-at-threshold and timeout, bit1 gates transmit empty, bit2 gates line error, and bit3 gates modem change. A masked source never raises `irq`.
- R5: A pulse on `ls_err_set` latches a line error. The latch clears on `lsr_rd` or on `rbr_st_rd`. A set in the same cycle as a clear wins.
- R6: The data-at-threshold source follows the `rx_at_thresh` level and drops as soon as that level falls.
- R7: The timeout source follows the `rx_timeout` level and ranks below data-at-threshold.
- R8: A rising edge of `thr_empty` arms the transmit-empty request. Reset does not count as a rising edge.
- R9: An `iid_rd` while code 1 is reported clears the transmit-empty request. An `iid_rd` while another code is reported leaves it armed.
- R10: Setting mask bit1 from 0 to 1 while `thr_empty` is high arms the transmit-empty request. A low `thr_empty` clears it.
- R11: A pulse on `ms_chg_set` latches a modem change. The latch clears on `msr_rd`, and a set in the same cycle as a clear wins.
- R12: Right after reset `irq` is 0 and `iid` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_wr | input | 1 | Enable mask write strobe |
| ien_wdata | input | 4 | Enable mask write value |
| ien_q | output | 4 | Current enable mask |
| ls_err_set | input | 1 | Receive line error event pulse |
| rx_at_thresh | input | 1 | Receive data count at or above threshold |
| rx_timeout | input | 1 | Receive character timeout level |
| thr_empty | input | 1 | Transmit holding register empty level |
| ms_chg_set | input | 1 | Modem input change event pulse |
| iid_rd | input | 1 | Identification read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| rbr_st_rd | input | 1 | Data read with status strobe |
| msr_rd | input | 1 | Modem status read strobe |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Identification word |

## Verification
The bench targets the places where priority and clearing interact. It lets several sources pend at once and then clears them one by one, so a swapped priority or code shows up as the wrong `iid`. It reads the identification while a line error hides a pending transmit-empty request, which catches a design that clears that request on any identification read. It also sets and clears the latched sources in the same cycle, which exposes a design where the clear wins, and it enables bit1 while the holding register is already empty, which exposes a design that arms only on the empty edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int MASK_W = 4;
  localparam int IID_W  = 4;
  localparam int SRC_N  = 5;
  localparam int CODE_W = IID_W - 1;

  // request vector index: lower index = higher priority
  localparam int IX_RLS  = 0;
  localparam int IX_RDA  = 1;
  localparam int IX_CTO  = 2;
  localparam int IX_THRE = 3;
  localparam int IX_MS   = 4;

  // mask bit positions
  localparam int MB_RX   = 0;
  localparam int MB_THRE = 1;
  localparam int MB_RLS  = 2;
  localparam int MB_MS   = 3;

  localparam logic [IID_W-1:0] IID_NONE = 4'b0001;

  // source code for a given request index
  function automatic logic [CODE_W-1:0] code_of_index(int ix);
    case (ix)
      IX_RLS:  return 3'd3;
      IX_RDA:  return 3'd2;
      IX_CTO:  return 3'd6;
      IX_THRE: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // isolate the highest-priority (lowest index) request
  function automatic logic [SRC_N-1:0] pick_first(logic [SRC_N-1:0] req);
    return req & (~req + SRC_N'(1));
  endfunction

  function automatic logic [IID_W-1:0] iid_encode(logic valid, logic [CODE_W-1:0] code);
    return valid ? {code, 1'b0} : IID_NONE;
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MASK_W-1:0] wdata,
  output logic [MASK_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata)); // R1
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R1
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q); // R5
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q); // R11
endmodule

// File: rtl/irq_thre_arm.sv
module irq_thre_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic en_q,
  input  logic en_wr,
  input  logic en_wbit,
  input  logic ack,
  output logic pend
);
  logic thr_d;
  logic thr_rise;
  logic en_arm;

  assign thr_rise = thr_empty && !thr_d;
  assign en_arm   = en_wr && en_wbit && !en_q && thr_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_d <= 1'b1;
      pend  <= 1'b0;
    end else begin
      thr_d <= thr_empty;
      if (thr_rise || en_arm) pend <= 1'b1;
      else if (!thr_empty)    pend <= 1'b0;
      else if (ack)           pend <= 1'b0;
    end
  end

  AST_THRE_RISE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_rise |=> pend); // R8
  AST_THRE_EN_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    en_arm |=> pend); // R10
  AST_THRE_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_empty |=> !pend); // R10
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req,
  output logic [SRC_N-1:0] grant,
  output logic             irq,
  output logic [IID_W-1:0] iid
);
  logic [CODE_W-1:0] code_part [SRC_N];
  logic [CODE_W-1:0] code;

  assign grant = pick_first(req);

  for (genvar g = 0; g < SRC_N; g++) begin : g_code
    assign code_part[g] = grant[g] ? code_of_index(g) : '0;
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < SRC_N; i++) code = code | code_part[i];
  end

  assign irq = |grant;
  assign iid = iid_encode(irq, code);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0); // R2
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (iid == IID_NONE && !irq)); // R3
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_wr,
  input  logic [MASK_W-1:0] ien_wdata,
  output logic [MASK_W-1:0] ien_q,
  input  logic             ls_err_set,
  input  logic             rx_at_thresh,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             ms_chg_set,
  input  logic             iid_rd,
  input  logic             lsr_rd,
  input  logic             rbr_st_rd,
  input  logic             msr_rd,
  output logic             irq,
  output logic [IID_W-1:0] iid
);
  logic             ls_pend;
  logic             ms_pend;
  logic             thre_pend;
  logic             thre_ack;
  logic [SRC_N-1:0] req;
  logic [SRC_N-1:0] grant;

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .wr(ien_wr), .wdata(ien_wdata), .q(ien_q)
  );

  irq_event_latch u_ls (
    .clk(clk), .rst_n(rst_n), .set_i(ls_err_set),
    .clr_i(lsr_rd || rbr_st_rd), .q(ls_pend)
  );

  irq_event_latch u_ms (
    .clk(clk), .rst_n(rst_n), .set_i(ms_chg_set), .clr_i(msr_rd), .q(ms_pend)
  );

  // only an identification read that reports the transmit source acks it
  assign thre_ack = iid_rd && grant[IX_THRE];

  irq_thre_arm u_thre (
    .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty), .en_q(ien_q[MB_THRE]),
    .en_wr(ien_wr), .en_wbit(ien_wdata[MB_THRE]), .ack(thre_ack), .pend(thre_pend)
  );

  always_comb begin
    req          = '0;
    req[IX_RLS]  = ls_pend      && ien_q[MB_RLS];
    req[IX_RDA]  = rx_at_thresh && ien_q[MB_RX];
    req[IX_CTO]  = rx_timeout   && ien_q[MB_RX];
    req[IX_THRE] = thre_pend    && ien_q[MB_THRE];
    req[IX_MS]   = ms_pend      && ien_q[MB_MS];
  end

  irq_prio_sel u_sel (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .irq(irq), .iid(iid)
  );

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R4
  AST_THRE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && iid == 4'b0010) |=> iid != 4'b0010); // R9
  AST_LS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_pend && ien_q[MB_RLS]) |-> iid == 4'b0110); // R2
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ien_wr = 0;
  logic [3:0] ien_wdata = 0;
  logic [3:0] ien_q;
  logic ls_err_set = 0, rx_at_thresh = 0, rx_timeout = 0, thr_empty = 1, ms_chg_set = 0;
  logic iid_rd = 0, lsr_rd = 0, rbr_st_rd = 0, msr_rd = 0;
  logic irq;
  logic [3:0] iid;

  uart_irq_ident dut (.*);

  always #10 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  // reference state
  bit m_ls, m_ms, m_thre, m_thrd;
  logic [3:0] m_mask;

  function automatic int exp_code();
    if (m_ls && m_mask[2]) return 3;
    if (rx_at_thresh && m_mask[0]) return 2;
    if (rx_timeout && m_mask[0]) return 6;
    if (m_thre && m_mask[1]) return 1;
    if (m_ms && m_mask[3]) return 0;
    return -1;
  endfunction

  task automatic model_reset();
    m_ls = 0; m_ms = 0; m_thre = 0; m_thrd = 1; m_mask = 0;
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ien_wr = 0; ls_err_set = 0; ms_chg_set = 0;
    iid_rd = 0; lsr_rd = 0; rbr_st_rd = 0; msr_rd = 0;
  endtask

  // compare now, then advance one clock and update the model
  task automatic cyc(string req);
    int c;
    logic [3:0] e;
    #2;
    c = exp_code();
    e = (c < 0) ? 4'b0001 : 4'(c * 2);
    chk("R1", ien_q, m_mask);
    chk(req, iid, e);
    chk("R3", {3'b0, irq}, {3'b0, c >= 0});
    @(posedge clk);
    if (thr_empty && !m_thrd) m_thre = 1;
    else if (ien_wr && ien_wdata[1] && !m_mask[1] && thr_empty) m_thre = 1;
    else if (!thr_empty) m_thre = 0;
    else if (iid_rd && c == 1) m_thre = 0;
    if (ls_err_set) m_ls = 1; else if (lsr_rd || rbr_st_rd) m_ls = 0;
    if (ms_chg_set) m_ms = 1; else if (msr_rd) m_ms = 0;
    m_thrd = thr_empty;
    if (ien_wr) m_mask = ien_wdata;
    @(negedge clk);
    idle();
  endtask

  task automatic wmask(logic [3:0] v, string req);
    ien_wr = 1; ien_wdata = v; cyc(req);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    cyc("R12");
    // R1: mask write, old value visible during write
    wmask(4'hF, "R1");
    cyc("R1");
    // R8: holding empty edge arms transmit request
    thr_empty = 0; cyc("R8");
    thr_empty = 1; cyc("R8");
    cyc("R8");
    // R9: identification read clears it
    iid_rd = 1; cyc("R9");
    cyc("R9");
    // R2 R5 R6 R7: stack sources and peel them off
    rx_at_thresh = 1; ls_err_set = 1; cyc("R6");
    cyc("R2");
    ls_err_set = 1; lsr_rd = 1; cyc("R5"); // set wins
    cyc("R5");
    rbr_st_rd = 1; cyc("R5");
    cyc("R6");
    rx_timeout = 1; cyc("R7");
    rx_at_thresh = 0; cyc("R7");
    rx_timeout = 0; cyc("R7");
    // R11: modem change latch
    ms_chg_set = 1; cyc("R11");
    ms_chg_set = 1; msr_rd = 1; cyc("R11");
    cyc("R11");
    msr_rd = 1; cyc("R11");
    cyc("R11");
    // R9: read while line error hides transmit request
    thr_empty = 0; cyc("R9");
    thr_empty = 1; ls_err_set = 1; cyc("R9");
    iid_rd = 1; cyc("R9");
    lsr_rd = 1; cyc("R9");
    cyc("R9");
    iid_rd = 1; cyc("R9");
    cyc("R9");
    // R4: masked sources stay quiet
    wmask(4'h0, "R4");
    ls_err_set = 1; ms_chg_set = 1; rx_at_thresh = 1; rx_timeout = 1; cyc("R4");
    cyc("R4");
    wmask(4'h8, "R4");
    cyc("R4");
    wmask(4'h4, "R4");
    cyc("R4");
    lsr_rd = 1; msr_rd = 1; rx_at_thresh = 0; rx_timeout = 0; cyc("R4");
    // R10: enabling bit1 while already empty arms; low empty clears
    wmask(4'h2, "R10");
    cyc("R10");
    thr_empty = 0; cyc("R10");
    cyc("R10");
    thr_empty = 1; wmask(4'h0, "R10");
    cyc("R10");
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ls_err_set = (r < 6);
      ms_chg_set = ($urandom_range(0, 99) < 6);
      lsr_rd     = ($urandom_range(0, 99) < 8);
      rbr_st_rd  = ($urandom_range(0, 99) < 8);
      msr_rd     = ($urandom_range(0, 99) < 8);
      iid_rd     = ($urandom_range(0, 99) < 20);
      if ($urandom_range(0, 99) < 10) rx_at_thresh = ~rx_at_thresh;
      if ($urandom_range(0, 99) < 10) rx_timeout = ~rx_timeout;
      if ($urandom_range(0, 99) < 12) thr_empty = ~thr_empty;
      if ($urandom_range(0, 99) < 5) begin
        ien_wr = 1; ien_wdata = 4'($urandom_range(0, 15));
      end
      cyc("R2");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule